// File: doc/BRIEF.md
# Multi-Cause Busy Generator with Burst Interlock

This block drives one BUSY line that tells an upstream trigger source to hold off. Several independent conditions can raise BUSY. The receiver may not be ready. The count of occupied event buffers may have reached a programmable limit. A hold timer runs after every level-1 accept. The trigger receiver may be busy. A leaky-bucket burst limiter may have filled. A sparse-mode two-buffer condition may be present. BUSY is the OR of all active conditions, and each one is reported as its own bit in a status word.

A free-running prescaler divides the clock into 10 µs steps of `STEP_CYCLES` cycles each, which is 400 cycles at 40 MHz. Both the hold timer and the bucket leak count in these steps. Each accept adds one unit to the bucket. The bucket loses one unit each leak period and never drops below zero. A 32-bit counter accumulates the clock cycles during which BUSY is high, and software reads it as two 16-bit halves.

Configuration and status use a small register port. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `busy_gen`

## Requirements
- R1: BUSY is high exactly when at least one cause is active. Status word (address 0) bit 15 is high when `rxReady` is low, and bit 12 is high when `trigRxBusy` is high.
- R2: Status bits 7:4 show the 4-bit buffer count. A `bufInc` pulse adds one, saturating at 15. A `bufDec` pulse subtracts one, saturating at 0. Both in the same cycle leave the count unchanged.
- R3: Status bits 3:0 hold the writable buffer limit, which resets to 4. Status bit 14 is high while count ≥ limit, so a limit of 0 keeps BUSY high.
- R4: The hold time (address 1, reset value 10) is counted in steps. After an `l1Accept`, status bit 13 is high for at least (H−1) and at most H whole steps. A hold time of 0 gives no hold.
- R5: BUSY stays high while bit 14 is active, even after the hold timer has expired.
- R6: The bucket level (0..63) rises by one per `l1Accept` and saturates at 63 rather than wrapping. Status bit 11 is high while the burst size (address 2, 6 bits) is nonzero and the level is ≥ the burst size. A burst size of 0 disables this cause.
- R7: With leak period P (address 3), the bucket loses one unit every P steps (every step when P is 0) and never goes below zero. An accept and a leak in the same cycle cancel each other.
- R8: The busy-time counter advances by one for every clock cycle in which BUSY is high. Address 5 reads its low half and address 6 its high half.
- R9: Status bit 10 is high only while mode register (address 4) bit 1 is set and `sparseTwoBuf` is high.
- R10: One step lasts `STEP_CYCLES` clock cycles (default 400), taken from a prescaler that runs freely from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| l1Accept | input | 1 | Level-1 accept strobe |
| bufInc | input | 1 | One buffer taken |
| bufDec | input | 1 | One buffer released |
| rxReady | input | 1 | Receiver ready flag |
| trigRxBusy | input | 1 | Trigger receiver busy flag |
| sparseTwoBuf | input | 1 | Sparse-mode two-buffer condition |
| busy | output | 1 | Combined busy output |

## Verification
BUSY and the status bits react to the flag inputs within the same cycle. They react to strobes and register writes from the first clock edge after the strobe, so the bench drives inputs on falling edges and samples one or more falling edges later. The hold timer and the bucket leak depend on the phase of the free-running prescaler. For these the bench checks at two points: a few cycles before the earliest possible release, where the cause must still be active, and a few cycles after the latest possible release, where it must be gone. The busy-time check holds one cause high for an exact number of rising edges and compares the difference in the counter to that number.

// File: rtl/busy_pkg.sv
package busy_pkg;
  localparam int CNT_W  = 4;
  localparam int LVL_W  = 6;
  localparam int TIME_W = 16;
  localparam int BT_W   = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_HOLD   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_BURST  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_LEAK   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_BTLO   = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_BTHI   = 3'd6;

  typedef struct packed {
    logic stepTick;
    logic leakPulse;
    logic holdActive;
  } ctrlStrobes_t;
endpackage

// File: rtl/busy_ctrl.sv
module busy_ctrl
  import busy_pkg::*;
#(
  parameter int STEP_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              l1Accept,
  input  logic [TIME_W-1:0] holdTime,
  input  logic [TIME_W-1:0] leakPeriod,
  output ctrlStrobes_t      strb
);
  localparam int PS_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(STEP_CYCLES - 1);

  logic [PS_W-1:0]   psCnt;
  logic [TIME_W-1:0] leakCnt;
  logic [TIME_W-1:0] holdCnt;
  logic              tick;
  logic              leakDue;

  assign tick    = (psCnt == PS_LAST);
  assign leakDue = tick && ((leakCnt + 1'b1) >= leakPeriod);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psCnt <= '0;
    else if (tick) psCnt <= '0;
    else psCnt <= psCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) leakCnt <= '0;
    else if (leakDue) leakCnt <= '0;
    else if (tick) leakCnt <= leakCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (l1Accept) holdCnt <= holdTime;
    else if (tick && holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  assign strb.stepTick   = tick;
  assign strb.leakPulse  = leakDue;
  assign strb.holdActive = (holdCnt != '0);

  // R4: a nonzero hold time starts the hold on the next cycle
  a_r4_hold_starts: assert property (@(posedge clk) disable iff (!rstN)
    (l1Accept && holdTime != '0) |=> strb.holdActive);

  // R10: step ticks are single-cycle pulses
  generate
    if (STEP_CYCLES > 1) begin : g_tickChk
      a_r10_tick_single: assert property (@(posedge clk) disable iff (!rstN)
        strb.stepTick |=> !strb.stepTick);
    end
  endgenerate
endmodule

// File: rtl/busy_dp.sv
module busy_dp
  import busy_pkg::*;
#(
  parameter int HOLD_RESET  = 10,
  parameter int LIMIT_RESET = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              l1Accept,
  input  logic              bufInc,
  input  logic              bufDec,
  input  logic              rxReady,
  input  logic              trigRxBusy,
  input  logic              sparseTwoBuf,
  input  ctrlStrobes_t      strb,
  output logic [TIME_W-1:0] holdTime,
  output logic [TIME_W-1:0] leakPeriod,
  output logic              busy
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic [CNT_W-1:0] bufLimit, bufCount;
  logic [LVL_W-1:0] burstSize, level;
  logic             sparseEn;
  logic [BT_W-1:0]  busyTime;
  logic [5:0]       causes;
  logic [15:0]      status;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufLimit   <= CNT_W'(LIMIT_RESET);
      holdTime   <= TIME_W'(HOLD_RESET);
      burstSize  <= '0;
      leakPeriod <= '0;
      sparseEn   <= 1'b0;
    end else if (regWe) begin
      case (regAddr)
        ADDR_STATUS: bufLimit   <= regWdata[CNT_W-1:0];
        ADDR_HOLD:   holdTime   <= regWdata[TIME_W-1:0];
        ADDR_BURST:  burstSize  <= regWdata[LVL_W-1:0];
        ADDR_LEAK:   leakPeriod <= regWdata[TIME_W-1:0];
        ADDR_MODE:   sparseEn   <= regWdata[1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufCount <= '0;
    else if (bufInc && !bufDec && bufCount != CNT_MAX) bufCount <= bufCount + 1'b1;
    else if (bufDec && !bufInc && bufCount != '0) bufCount <= bufCount - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) level <= '0;
    else if (l1Accept && !strb.leakPulse && level != LVL_MAX) level <= level + 1'b1;
    else if (strb.leakPulse && !l1Accept && level != '0) level <= level - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyTime <= '0;
    else if (busy) busyTime <= busyTime + 1'b1;
  end

  assign causes = {!rxReady,
                   (bufCount >= bufLimit),
                   strb.holdActive,
                   trigRxBusy,
                   (burstSize != '0) && (level >= burstSize),
                   sparseEn && sparseTwoBuf};
  assign busy   = |causes;
  assign status = {causes, 2'b00, bufCount, bufLimit};

  always_comb begin
    case (regAddr)
      ADDR_STATUS: regRdata = status;
      ADDR_HOLD:   regRdata = holdTime;
      ADDR_BURST:  regRdata = 16'(burstSize);
      ADDR_LEAK:   regRdata = leakPeriod;
      ADDR_MODE:   regRdata = {14'd0, sparseEn, 1'b0};
      ADDR_BTLO:   regRdata = busyTime[15:0];
      ADDR_BTHI:   regRdata = busyTime[31:16];
      default:     regRdata = '0;
    endcase
  end

  // R2: the buffer count holds at its top value
  a_r2_count_sat: assert property (@(posedge clk) disable iff (!rstN)
    (bufInc && !bufDec && bufCount == CNT_MAX) |=> bufCount == CNT_MAX);

  // R7: a leak on an empty bucket leaves it empty
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (strb.leakPulse && !l1Accept && level == '0) |=> level == '0);

  // R8: the busy-time counter is frozen while idle
  a_r8_idle_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(busyTime));

  // R6: the bucket never wraps from full to empty
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (level == LVL_MAX && !strb.leakPulse) |=> level == LVL_MAX);
endmodule

// File: rtl/busy_gen.sv
module busy_gen
  import busy_pkg::*;
#(
  parameter int STEP_CYCLES = 400,
  parameter int HOLD_RESET  = 10,
  parameter int LIMIT_RESET = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        l1Accept,
  input  logic        bufInc,
  input  logic        bufDec,
  input  logic        rxReady,
  input  logic        trigRxBusy,
  input  logic        sparseTwoBuf,
  output logic        busy
);
  ctrlStrobes_t      strb;
  logic [TIME_W-1:0] holdTime;
  logic [TIME_W-1:0] leakPeriod;

  busy_ctrl #(.STEP_CYCLES(STEP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .l1Accept(l1Accept),
    .holdTime(holdTime), .leakPeriod(leakPeriod), .strb(strb)
  );

  busy_dp #(.HOLD_RESET(HOLD_RESET), .LIMIT_RESET(LIMIT_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .l1Accept(l1Accept),
    .bufInc(bufInc), .bufDec(bufDec), .rxReady(rxReady),
    .trigRxBusy(trigRxBusy), .sparseTwoBuf(sparseTwoBuf), .strb(strb),
    .holdTime(holdTime), .leakPeriod(leakPeriod), .busy(busy)
  );

  // R1: a flag input that raises a cause raises BUSY at once
  a_r1_flags_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!rxReady || trigRxBusy) |-> busy);
endmodule

// File: tb/sim_busy_gen.sv
`timescale 1ns/1ps
module sim_busy_gen;
  localparam int STEP = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic l1Accept = 1'b0, bufInc = 1'b0, bufDec = 1'b0;
  logic rxReady = 1'b1, trigRxBusy = 1'b0, sparseTwoBuf = 1'b0;
  logic busy;
  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  busy_gen #(.STEP_CYCLES(STEP)) u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .l1Accept(l1Accept),
    .bufInc(bufInc), .bufDec(bufDec), .rxReady(rxReady),
    .trigRxBusy(trigRxBusy), .sparseTwoBuf(sparseTwoBuf), .busy(busy)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic accept();
    @(negedge clk); l1Accept = 1'b1;
    @(negedge clk); l1Accept = 1'b0;
  endtask

  task automatic pulseBuf(bit inc, bit dec);
    @(negedge clk); bufInc = inc; bufDec = dec;
    @(negedge clk); bufInc = 1'b0; bufDec = 1'b0;
  endtask

  task automatic testReset();
    logic [15:0] d;
    rd(3'd0, d);
    check("R3 reset status", 32'(d), 32'h0004);
    rd(3'd1, d);
    check("R4 reset hold", 32'(d), 32'd10);
    check("R1 reset busy", 32'(busy), 32'd0);
  endtask

  task automatic testFlags();
    logic [15:0] d;
    @(negedge clk); rxReady = 1'b0; #1;
    rd(3'd0, d);
    check("R1 bit15", 32'(d[15:10]), 32'b100000);
    check("R1 busy rx", 32'(busy), 32'd1);
    rxReady = 1'b1; trigRxBusy = 1'b1; #1;
    rd(3'd0, d);
    check("R1 bit12", 32'(d[15:10]), 32'b000100);
    trigRxBusy = 1'b0; #1;
    check("R1 idle", 32'(busy), 32'd0);
  endtask

  task automatic testHold();
    logic [15:0] d;
    wr(3'd1, 16'd2);
    accept();
    waitCyc(2); rd(3'd0, d);
    check("R4 hold on", 32'(d[13]), 32'd1);
    waitCyc(STEP - 8); rd(3'd0, d);
    check("R4 hold min", 32'(d[13]), 32'd1);
    waitCyc(STEP + 12); rd(3'd0, d);
    check("R4 hold max", 32'(d[13]), 32'd0);
    check("R4 busy off", 32'(busy), 32'd0);
    wr(3'd1, 16'd0);
    accept();
    waitCyc(2); rd(3'd0, d);
    check("R4 hold zero", 32'(d[13]), 32'd0);
    waitCyc(2 * STEP);
  endtask

  task automatic testBuffers();
    logic [15:0] d;
    repeat (20) pulseBuf(1'b1, 1'b0);
    rd(3'd0, d);
    check("R2 sat high", 32'(d[7:4]), 32'd15);
    pulseBuf(1'b1, 1'b1);
    rd(3'd0, d);
    check("R2 both", 32'(d[7:4]), 32'd15);
    pulseBuf(1'b0, 1'b1);
    rd(3'd0, d);
    check("R2 dec", 32'(d[7:4]), 32'd14);
    repeat (20) pulseBuf(1'b0, 1'b1);
    rd(3'd0, d);
    check("R2 sat low", 32'(d[7:4]), 32'd0);
    wr(3'd0, 16'd0);
    rd(3'd0, d);
    check("R3 limit zero", 32'(d[14]), 32'd1);
    wr(3'd0, 16'd2);
    pulseBuf(1'b1, 1'b0);
    rd(3'd0, d);
    check("R3 below limit", 32'(d[14]), 32'd0);
    pulseBuf(1'b1, 1'b0);
    rd(3'd0, d);
    check("R3 at limit", 32'({d[14], d[3:0]}), 32'h12);
  endtask

  task automatic testHoldAndFull();
    logic [15:0] d;
    wr(3'd1, 16'd1);
    accept();
    waitCyc(STEP + 8); rd(3'd0, d);
    check("R5 hold gone", 32'(d[13]), 32'd0);
    check("R5 busy full", 32'(busy), 32'd1);
    pulseBuf(1'b0, 1'b1);
    rd(3'd0, d);
    check("R5 released", 32'({busy, d[14], d[7:4]}), 32'h01);
    pulseBuf(1'b0, 1'b1);
    wr(3'd1, 16'd0);
  endtask

  task automatic testBurst();
    logic [15:0] d;
    wr(3'd3, 16'd1);
    repeat (5) accept();
    rd(3'd0, d);
    check("R6 disabled", 32'(d[11]), 32'd0);
    waitCyc(6 * STEP);
    wr(3'd2, 16'd1);
    rd(3'd0, d);
    check("R7 drained", 32'(d[11]), 32'd0);
    repeat (3) accept();
    rd(3'd0, d);
    check("R6 burst on", 32'(d[11]), 32'd1);
    waitCyc(2 * STEP - 10); rd(3'd0, d);
    check("R7 leak min", 32'(d[11]), 32'd1);
    waitCyc(STEP + 20); rd(3'd0, d);
    check("R7 leak max", 32'(d[11]), 32'd0);
    wr(3'd3, 16'd1000);
    wr(3'd2, 16'd63);
    repeat (70) accept();
    rd(3'd0, d);
    check("R6 saturate", 32'(d[11]), 32'd1);
    wr(3'd2, 16'd0);
    wr(3'd3, 16'd0);
    waitCyc(66 * STEP);
  endtask

  task automatic testSparse();
    logic [15:0] d;
    @(negedge clk); sparseTwoBuf = 1'b1; #1;
    rd(3'd0, d);
    check("R9 gated", 32'({busy, d[10]}), 32'd0);
    wr(3'd4, 16'h0002);
    rd(3'd0, d);
    check("R9 active", 32'({busy, d[10]}), 32'b11);
    wr(3'd4, 16'h0000);
    sparseTwoBuf = 1'b0;
  endtask

  task automatic testBusyTime();
    logic [15:0] lo, hi;
    logic [31:0] t0, t1;
    rd(3'd5, lo); rd(3'd6, hi);
    t0 = {hi, lo};
    @(negedge clk); rxReady = 1'b0;
    waitCyc(37); rxReady = 1'b1;
    waitCyc(3);
    rd(3'd5, lo); rd(3'd6, hi);
    t1 = {hi, lo};
    check("R8 busy time", t1 - t0, 32'd37);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    testReset();
    testFlags();
    testHold();
    testBuffers();
    testHoldAndFull();
    testBurst();
    testSparse();
    testBusyTime();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        nTests++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule